// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial bus engine in a byte-addressed non-volatile memory model. The engine hands it a word address, then a run of data bytes, then either an end-of-transaction strobe or an abort. The bytes go into a one-page holding latch that has a valid flag per byte. They reach the storage array only when the transaction ends cleanly.

A commit writes every latched byte in a single clock. It then starts a lockout of a set number of clock cycles that stands in for the cell programming time. During the lockout the block refuses bus writes and reads. A power-up lockout of its own length covers the period right after reset. Reads come through a simple registered port.

Top module: `pgwr_store`

## Requirements
- R1: After reset is released, `busy` stays high for exactly POR_CYCLES clock cycles and then falls.
- R2: Data bytes go to consecutive locations starting at the loaded address. Only address bits 4:0 advance, and bits 10:5 (the page) stay fixed. A run that starts at 0x3E therefore lands at 0x3E, 0x3F and then 0x20.
- R3: When more than 32 bytes arrive before the end strobe, each later byte replaces the earlier byte at the same page offset. With 33 bytes from offset 0, offset 0 holds the 33rd byte.
- R4: The array does not change until `stop_stb` is accepted. A read taken before the end strobe returns the old contents.
- R5: A commit writes only the page offsets that received a byte. Every other location keeps its previous value.
- R6: An `abort_stb`, or a new `addr_stb` before the end strobe, discards all latched bytes. A later end strobe then writes nothing and starts no lockout.
- R7: An accepted `stop_stb` with at least one latched byte raises `busy` on the next clock. `busy` then stays high for exactly WRITE_CYCLES cycles.
- R8: While `busy` is high, `addr_stb`, `data_stb`, `stop_stb` and `rd_stb` have no effect. No `rd_ack` is given, and no byte reaches the array.
- R9: A `rd_stb` while idle gives `rd_ack` high for one cycle on the next clock. In that cycle `rd_data` holds the byte at `rd_addr`. After reset every location reads 0x00.
- R10: The valid flags clear when a commit happens. A second `stop_stb` with no new bytes starts no lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_stb | input | 1 | Load the word address and start a transaction |
| addr_in | input | 11 | Word address |
| data_stb | input | 1 | One data byte for the page latch |
| data_in | input | 8 | Data byte |
| stop_stb | input | 1 | End of transaction, commit request |
| abort_stb | input | 1 | Transaction dropped, discard latch |
| rd_stb | input | 1 | Read request |
| rd_addr | input | 11 | Read address |
| rd_data | output | 8 | Read result |
| rd_ack | output | 1 | Read result valid |
| busy | output | 1 | Power-up or write-cycle lockout |

## Verification
A run that crosses a page boundary shows whether the address stays inside its page or carries into the next one. A 33-byte run shows whether the latch overwrites or spills over. A single byte written into a page that is already filled shows whether a commit writes the whole page or only the flagged bytes. The abort and restart sequences, the repeated end strobe and the attempted accesses during a lockout show whether latched data is dropped, and whether inputs are gated, exactly when required. Measuring how long `busy` stays high checks both lockout lengths.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int unsigned ADDR_W     = 11;
  localparam int unsigned OFS_W      = 5;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned PAGE_W     = ADDR_W - OFS_W;
  localparam int unsigned PAGE_BYTES = 1 << OFS_W;
  localparam int unsigned MEM_BYTES  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [OFS_W-1:0]  ofs_t;

  function automatic page_t page_of(addr_t a);
    return a[ADDR_W-1:OFS_W];
  endfunction

  function automatic ofs_t ofs_of(addr_t a);
    return a[OFS_W-1:0];
  endfunction

  function automatic addr_t join_addr(page_t p, ofs_t o);
    return {p, o};
  endfunction

  // advance within the page: offset wraps, page bits untouched
  function automatic addr_t step_in_page(addr_t a);
    ofs_t o;
    o = ofs_of(a) + ofs_t'(1);
    return join_addr(page_of(a), o);
  endfunction
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch
  import pgwr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic                 addr_stb,
  input  addr_t                addr_in,
  input  logic                 data_stb,
  input  byte_t                data_in,
  input  logic                 stop_stb,
  input  logic                 abort_stb,
  output logic                 commit_fire,
  output page_t                commit_page,
  output byte_t                lat_data [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] lat_vld
);
  addr_t ptr;
  logic  addr_acc, data_acc, stop_acc;

  assign addr_acc    = accept & addr_stb & ~abort_stb;
  assign data_acc    = accept & data_stb & ~abort_stb & ~addr_stb;
  assign stop_acc    = accept & stop_stb & ~abort_stb & ~addr_stb & ~data_stb;
  assign commit_fire = stop_acc & (|lat_vld);
  assign commit_page = page_of(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      lat_vld <= '0;
    end else if (abort_stb) begin
      lat_vld <= '0;
    end else if (addr_acc) begin
      ptr     <= addr_in;
      lat_vld <= '0;
    end else if (data_acc) begin
      lat_vld[ofs_of(ptr)] <= 1'b1;
      ptr                  <= step_in_page(ptr);
    end else if (stop_acc) begin
      lat_vld <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (data_acc) lat_data[ofs_of(ptr)] <= data_in;
  end

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    data_acc |=> page_of(ptr) == page_of($past(ptr))); // R2
  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    abort_stb |=> !commit_fire); // R6
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
  import pgwr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_fire,
  input  page_t                 commit_page,
  input  byte_t                 lat_data [PAGE_BYTES],
  input  logic [PAGE_BYTES-1:0] lat_vld,
  input  logic                  rd_acc,
  input  addr_t                 rd_addr,
  output byte_t                 rd_data,
  output logic                  rd_ack
);
  byte_t mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MEM_BYTES; k++) mem[k] <= '0;
    end else if (commit_fire) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (lat_vld[i]) mem[join_addr(commit_page, ofs_t'(i))] <= lat_data[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_ack  <= 1'b0;
    end else begin
      rd_ack <= rd_acc;
      if (rd_acc) rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int unsigned WRITE_CYCLES = 40,
  parameter int unsigned POR_CYCLES   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_fire,
  output logic busy
);
  localparam int unsigned WC_W  = $clog2(WRITE_CYCLES + 1);
  localparam int unsigned POR_W = $clog2(POR_CYCLES + 1);

  logic [WC_W-1:0]  wc_cnt;
  logic [POR_W-1:0] por_cnt;
  logic             por_busy, wc_busy;

  assign por_busy = por_cnt < POR_W'(POR_CYCLES);
  assign wc_busy  = wc_cnt != '0;
  assign busy     = por_busy | wc_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        por_cnt <= '0;
    else if (por_busy) por_cnt <= por_cnt + POR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          wc_cnt <= '0;
    else if (commit_fire) wc_cnt <= WC_W'(WRITE_CYCLES);
    else if (wc_busy)    wc_cnt <= wc_cnt - WC_W'(1);
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wc_cnt > WC_W'(1)) |=> wc_busy); // R7
  AST_POR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_busy) |-> por_cnt == POR_W'(POR_CYCLES)); // R1
endmodule

// File: rtl/pgwr_store.sv
module pgwr_store
  import pgwr_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 40,
  parameter int unsigned POR_CYCLES   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] data_in,
  input  logic              stop_stb,
  input  logic              abort_stb,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ack,
  output logic              busy
);
  logic                  commit_fire;
  page_t                 commit_page;
  byte_t                 lat_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] lat_vld;
  logic                  accept, rd_acc;

  assign accept = ~busy;
  assign rd_acc = rd_stb & ~busy;

  pgwr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .addr_stb(addr_stb), .addr_in(addr_in),
    .data_stb(data_stb), .data_in(data_in),
    .stop_stb(stop_stb), .abort_stb(abort_stb),
    .commit_fire(commit_fire), .commit_page(commit_page),
    .lat_data(lat_data), .lat_vld(lat_vld)
  );

  pgwr_array u_array (
    .clk(clk), .rst_n(rst_n), .commit_fire(commit_fire),
    .commit_page(commit_page), .lat_data(lat_data), .lat_vld(lat_vld),
    .rd_acc(rd_acc), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ack(rd_ack)
  );

  pgwr_timer #(.WRITE_CYCLES(WRITE_CYCLES), .POR_CYCLES(POR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .commit_fire(commit_fire), .busy(busy)
  );

  AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |-> !busy); // R8
  AST_COMMIT_START: assert property (@(posedge clk) disable iff (!rst_n)
    commit_fire |=> busy); // R7
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(!busy)); // R8
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> $past(rd_stb)); // R9
endmodule

// File: tb/pgwr_store_test.sv
module pgwr_store_test;
  localparam int WC  = 40;
  localparam int POR = 16;

  logic        clk = 0, rst_n = 0;
  logic        addr_stb = 0, data_stb = 0, stop_stb = 0, abort_stb = 0, rd_stb = 0;
  logic [10:0] addr_in = 0, rd_addr = 0;
  logic [7:0]  data_in = 0;
  logic [7:0]  rd_data;
  logic        rd_ack, busy;

  int compared = 0, mismatched = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  pgwr_store #(.WRITE_CYCLES(WC), .POR_CYCLES(POR)) uut (
    .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .addr_in(addr_in),
    .data_stb(data_stb), .data_in(data_in), .stop_stb(stop_stb),
    .abort_stb(abort_stb), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ack(rd_ack), .busy(busy));

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop expected read results as acks appear
  always @(negedge clk) begin
    if (rst_n && rd_ack) begin
      if (exp_q.size() == 0) chk("R8 unexpected rd_ack", 1, 0);
      else begin
        string t;
        logic [7:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        chk(t, int'(rd_data), int'(e));
      end
    end
  end

  task automatic wr_addr(logic [10:0] a);
    @(posedge clk); #1; addr_stb = 1; addr_in = a;
    @(posedge clk); #1; addr_stb = 0;
  endtask
  task automatic wr_byte(logic [7:0] d);
    @(posedge clk); #1; data_stb = 1; data_in = d;
    @(posedge clk); #1; data_stb = 0;
  endtask
  task automatic do_stop();
    @(posedge clk); #1; stop_stb = 1;
    @(posedge clk); #1; stop_stb = 0;
  endtask
  task automatic do_abort();
    @(posedge clk); #1; abort_stb = 1;
    @(posedge clk); #1; abort_stb = 0;
  endtask
  task automatic rd(logic [10:0] a, logic [7:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1; rd_stb = 1; rd_addr = a;
    @(posedge clk); #1; rd_stb = 0;
    @(negedge clk);
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask
  task automatic measure_busy(string t, int exp);
    int n = 0;
    @(negedge clk);
    while (busy && n < 10*WC) begin n++; @(negedge clk); end
    chk(t, n, exp);
  endtask

  initial begin
    #(200000 * 5);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 busy in reset", int'(busy), 1);
    chk("R9 rd_ack in reset", int'(rd_ack), 0);
    @(posedge clk); #1; rst_n = 1;
    measure_busy("R1 power-up lockout length", POR);

    rd(11'h005, 8'h00, "R9 reset contents");

    // page-crossing run
    wr_addr(11'h03E);
    wr_byte(8'hA1); wr_byte(8'hA2); wr_byte(8'hA3);
    rd(11'h03E, 8'h00, "R4 no write before stop");
    do_stop();
    measure_busy("R7 write lockout length", WC);
    rd(11'h03E, 8'hA1, "R2 first byte");
    rd(11'h03F, 8'hA2, "R2 second byte");
    rd(11'h020, 8'hA3, "R2 wrap 3F->20");
    rd(11'h040, 8'h00, "R2 next page untouched");
    rd(11'h021, 8'h00, "R5 unflagged offset kept");

    // 33-byte run
    wr_addr(11'h080);
    for (int i = 0; i < 33; i++) wr_byte(8'(i + 1));
    do_stop();
    wait_idle();
    rd(11'h080, 8'd33, "R3 offset 0 overwritten");
    rd(11'h081, 8'd2,  "R3 offset 1");
    rd(11'h09F, 8'd32, "R3 offset 31");
    rd(11'h0A0, 8'h00, "R3 no spill");

    // single byte into filled page, then access during lockout
    wr_addr(11'h082); wr_byte(8'hC3);
    do_stop();
    @(negedge clk);
    chk("R7 busy after commit", int'(busy), 1);
    @(posedge clk); #1; rd_stb = 1; rd_addr = 11'h082;
    @(posedge clk); #1; rd_stb = 0;
    @(negedge clk);
    chk("R8 no rd_ack while busy", int'(rd_ack), 0);
    wr_addr(11'h100); wr_byte(8'h55); do_stop();
    wait_idle();
    rd(11'h082, 8'hC3, "R5 new byte");
    rd(11'h083, 8'd4,  "R5 neighbour kept");
    rd(11'h080, 8'd33, "R5 offset 0 kept");
    rd(11'h100, 8'h00, "R8 write during busy ignored");

    // abort and restart
    wr_addr(11'h300); wr_byte(8'h77); do_abort();
    @(negedge clk);
    chk("R6 no busy after abort", int'(busy), 0);
    do_stop();
    @(negedge clk);
    chk("R6 stop after abort no lockout", int'(busy), 0);
    rd(11'h300, 8'h00, "R6 aborted byte dropped");
    wr_addr(11'h310); wr_byte(8'h11);
    wr_addr(11'h320); wr_byte(8'h22);
    do_stop();
    wait_idle();
    rd(11'h310, 8'h00, "R6 restart drops first");
    rd(11'h320, 8'h22, "R6 restart keeps second");

    // repeated stop
    do_stop();
    @(negedge clk);
    chk("R10 second stop no lockout", int'(busy), 0);

    repeat (4) @(negedge clk);
    chk("R9 all reads answered", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule